// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Overrun Handling

This block is a byte-wide synchronous serial transceiver attached to a small processor register bus. Software programs a control register, loads bytes into a transmit buffer and collects received bytes from a receive buffer. A status register reports the state of the port. Every transfer moves exactly eight bits in each direction at once, least significant bit first. The outgoing bit changes on the falling edge of the serial clock, and the incoming bit is sampled on the rising edge.

The serial clock has two possible sources. The port can generate it from the system clock with a fixed divider, in which case it drives the clock pin. It can also take the clock from an input pin. In that case the pin passes through a two-flop synchroniser and an edge detector, so each high phase and each low phase must last at least eight system-clock periods. A ready output tells a remote master that a byte is waiting to be shifted. It is only driven when the port enable, transmit enable, receive enable and ready-output enable bits are all set.

A receive overrun happens when a new byte completes while the previous one is still unread. On an overrun the new byte is dropped and the buffer keeps the old byte. Two flags are then raised: an overrun flag and a sticky summary error flag. Software can clear the overrun flag in three ways, and they differ in what they do to the summary flag.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register reads 0x00 and the status register reads 0x06. The serial clock output and the data output idle high, and both output enables are low. Status bits: bit0 rx_full, bit1 tx_empty, bit2 tx_done, bit3 overrun, bit4 err_sum.
- R2: Each transfer is exactly eight serial clock cycles. The data output presents the transmit byte LSB first. Each bit changes after a falling edge and is stable across the following rising edge.
- R3: The data input is sampled on each rising edge, LSB first. When the receiver is enabled and the receive buffer is empty, the whole byte is placed in the receive buffer (address 2) at the end of the transfer.
- R4: rx_full is set when a byte enters the receive buffer. Reading address 2 clears it.
- R5: After a write to the transmit buffer, tx_done stays 1 until the first falling serial clock edge that starts the transfer, and only then goes to 0. It returns to 1 at the end of the transfer.
- R6: When a byte completes while rx_full is 1 and the receiver is enabled, both overrun and err_sum become 1.
- R7: On an overrun the receive buffer keeps the byte it held before.
- R8: Writing the control register with port enable (bit0) at 0 clears overrun only. err_sum keeps its value.
- R9: Any write to the status register (address 1), whatever the data, clears both overrun and err_sum.
- R10: Writing the control register with receive enable (bit2) at 0 clears both overrun and err_sum.
- R11: srdy_oe is 1 only when control bits 0 (port enable), 1 (transmit enable), 2 (receive enable) and 3 (ready-output enable) are all 1. srdy is high while a transmit byte waits and no transfer is in progress.
- R12: With external clock selected (control bit4 = 1), sclk_oe is 0 and transfers are paced by sclk_in. With the internal clock selected and the port enabled, sclk_oe is 1.
- R13: With the external clock selected and sclk_in held steady, no bits are shifted: the transmit byte stays buffered and tx_done stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read pops rx_full) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sclk_in | input | 1 | External serial clock pin |
| sclk_out | output | 1 | Internally generated serial clock |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| srdy | output | 1 | Ready indication to a remote master |
| srdy_oe | output | 1 | Drive enable for the ready output |

## Verification
The overrun-recovery paths are the hardest conditions to reach from the ports. Each one needs an unread byte in the receive buffer, then a second complete transfer, and then a specific control or status write. The bench runs loopback transfers on the internal clock, with sdo fed back to sdi. It leaves the receive buffer unread across several frames and sets up the overrun again before each of the three clear paths. Only after all three does it read the buffer to confirm that the first byte survived. External-clock operation is covered by a bench-driven sclk_in whose phases are exactly eight system clocks long. This is the shortest phase the synchroniser accepts.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // control register, bit0 at the bottom
  typedef struct packed {
    logic ext_clk;
    logic rdy_oe;
    logic rx_en;
    logic tx_en;
    logic port_en;
  } ctrl_t;

  // status register, bit0 at the bottom
  typedef struct packed {
    logic err_sum;
    logic ovr;
    logic tx_done;
    logic tx_empty;
    logic rx_full;
  } stat_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/ssp_sclk_gen.sv
module ssp_sclk_gen #(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic run_ext,
  input  logic run_int,
  input  logic sclk_in,
  output logic sclk_out,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  // external path: synchroniser plus edge detect
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   ext_fall, ext_rise;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], sclk_in};
    end else begin : g_single
      assign sync_d = sclk_in;
    end
  endgenerate

  assign prev_d   = sync_q[SYNC_STAGES-1];
  assign ext_fall = run_ext &  prev_q & ~sync_q[SYNC_STAGES-1];
  assign ext_rise = run_ext & ~prev_q &  sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // internal path: half-period divider, idles high
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             active, tick;

  always_comb begin
    active = run_int | ~lvl_q;
    tick   = active & (cnt_q == CNT_LAST);
    cnt_d  = '0;
    if (active && !tick) cnt_d = cnt_q + 1'b1;
    lvl_d  = tick ? ~lvl_q : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign sclk_out = lvl_q;
  assign fall_ev  = use_ext ? ext_fall : (tick &  lvl_q);
  assign rise_ev  = use_ext ? ext_rise : (tick & ~lvl_q);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         tx_pending,
  input  logic [W-1:0] tx_data,
  input  logic         sdi,
  output logic         tx_take,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     tx_sh_q, tx_sh_d;
  logic [W-1:0]     rx_sh_q, rx_sh_d;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    done_d  = 1'b0;
    tx_take = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
    end else begin
      if (fall_ev) begin
        if (!busy_q) begin
          busy_d  = 1'b1;
          cnt_d   = '0;
          tx_take = tx_pending;
          tx_sh_d = tx_pending ? tx_data : '1;
        end else begin
          tx_sh_d = {1'b1, tx_sh_q[W-1:1]};
        end
      end
      if (rise_ev && busy_q) begin
        rx_sh_d = {sdi, rx_sh_q[W-1:1]};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      tx_sh_q <= '1;
      rx_sh_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
    end
  end

  assign sdo     = busy_q ? tx_sh_q[0] : 1'b1;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_sh_q;
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         tx_take,
  input  logic         done,
  input  logic [W-1:0] rx_word,
  output ctrl_t        ctrl,
  output logic         tx_full,
  output logic [W-1:0] tx_buf,
  output stat_t        status,
  output logic [W-1:0] rx_buf
);
  ctrl_t        ctrl_q, ctrl_d;
  logic [W-1:0] txb_q, txb_d;
  logic [W-1:0] rxb_q, rxb_d;
  logic         txf_q, txf_d;
  logic         rxf_q, rxf_d;
  logic         txdone_q, txdone_d;
  logic         ovr_q, ovr_d;
  logic         err_q, err_d;
  logic         wr_ctrl, wr_stat, wr_data, rd_data;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_stat = wr && (addr == A_STAT);
  assign wr_data = wr && (addr == A_DATA);
  assign rd_data = rd && (addr == A_DATA);

  always_comb begin
    ctrl_d   = ctrl_q;
    txb_d    = txb_q;
    rxb_d    = rxb_q;
    txf_d    = txf_q;
    rxf_d    = rxf_q;
    txdone_d = txdone_q;
    ovr_d    = ovr_q;
    err_d    = err_q;
    if (wr_ctrl) begin
      ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
      if (!ctrl_d.port_en) ovr_d = 1'b0;
      if (!ctrl_d.rx_en) begin
        ovr_d = 1'b0;
        err_d = 1'b0;
      end
    end
    if (wr_stat) begin
      ovr_d = 1'b0;
      err_d = 1'b0;
    end
    if (tx_take) begin
      txf_d    = 1'b0;
      txdone_d = 1'b0;
    end
    if (wr_data) begin
      txb_d = wdata;
      txf_d = 1'b1;
    end
    if (rd_data) rxf_d = 1'b0;
    if (done) begin
      txdone_d = 1'b1;
      if (ctrl_q.rx_en) begin
        if (rxf_q) begin
          ovr_d = 1'b1;
          err_d = 1'b1;
        end else begin
          rxb_d = rx_word;
          rxf_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      txb_q    <= '0;
      rxb_q    <= '0;
      txf_q    <= 1'b0;
      rxf_q    <= 1'b0;
      txdone_q <= 1'b1;
      ovr_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      txb_q    <= txb_d;
      rxb_q    <= rxb_d;
      txf_q    <= txf_d;
      rxf_q    <= rxf_d;
      txdone_q <= txdone_d;
      ovr_q    <= ovr_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    status.rx_full  = rxf_q;
    status.tx_empty = ~txf_q;
    status.tx_done  = txdone_q;
    status.ovr      = ovr_q;
    status.err_sum  = err_q;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = W'(ctrl_q);
      A_STAT:  rdata = W'(status);
      A_DATA:  rdata = rxb_q;
      default: rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign tx_full = txf_q;
  assign tx_buf  = txb_q;
  assign rx_buf  = rxb_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              srdy,
  output logic              srdy_oe
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  ctrl_t              ctrl;
  stat_t              status;
  logic               tx_full, tx_take, busy, done;
  logic               fall_ev, rise_ev, run_int, run_ext, abort;
  logic [DATA_W-1:0]  tx_buf, rx_buf, rx_word;

  assign abort   = ~ctrl.port_en;
  assign run_int = ctrl.port_en & ctrl.tx_en & ~ctrl.ext_clk & (busy | tx_full);
  assign run_ext = ctrl.port_en & ctrl.ext_clk & (ctrl.tx_en | ctrl.rx_en);

  ssp_sclk_gen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_ni), .use_ext(ctrl.ext_clk), .run_ext(run_ext),
    .run_int(run_int), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  ssp_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .abort(abort), .fall_ev(fall_ev),
    .rise_ev(rise_ev), .tx_pending(tx_full), .tx_data(tx_buf), .sdi(sdi),
    .tx_take(tx_take), .sdo(sdo), .busy(busy), .done(done), .rx_word(rx_word)
  );

  ssp_regs #(.W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .tx_take(tx_take), .done(done),
    .rx_word(rx_word), .ctrl(ctrl), .tx_full(tx_full), .tx_buf(tx_buf),
    .status(status), .rx_buf(rx_buf)
  );

  assign sclk_oe = ctrl.port_en & ~ctrl.ext_clk;
  assign srdy_oe = ctrl.port_en & ctrl.tx_en & ctrl.rx_en & ctrl.rdy_oe;
  assign srdy    = srdy_oe & tx_full & ~busy;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fall_ev,
  input logic         rise_ev,
  input logic         abort,
  input logic         done,
  input logic         sdo,
  input logic         tx_done,
  input logic         ovr,
  input logic         err_sum,
  input logic         rx_full,
  input logic [W-1:0] rx_buf
);
  // R6
  ovr_raises_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> err_sum);

  // R7
  ovr_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rx_buf));

  // R2
  sdo_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(fall_ev || rise_ev || abort));

  // R5
  txdone_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $past(fall_ev));

  // R4
  rxfull_from_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(done));
endmodule

bind sync_serial_port ssp_checker #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_ni), .fall_ev(fall_ev), .rise_ev(rise_ev),
  .abort(abort), .done(done), .sdo(sdo), .tx_done(status.tx_done),
  .ovr(status.ovr), .err_sum(status.err_sum), .rx_full(status.rx_full),
  .rx_buf(rx_buf)
);

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_WAIT = 90;

  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       sclk_in, sclk_out, sclk_oe;
  logic       sdi, sdo, srdy, srdy_oe;
  logic       loop_en, ext_mode, sdi_drv;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] exp_q [$];

  assign sdi = loop_en ? sdo : sdi_drv;

  sync_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdi(sdi), .sdo(sdo), .srdy(srdy), .srdy_oe(srdy_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: queue the byte the monitor must see on sdo, then load it
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    bus_write(2'd2, b);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_stat(input logic [7:0] e, input string req);
    logic [7:0] v;
    bus_read(2'd1, v);
    check(v == e, req, v, e);
  endtask

  // external clock frame, phases of eight system clocks, sdi from b
  task automatic ext_frame(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_in = 1'b0; sdi_drv = b[i];
      wait_cyc(8);
      sclk_in = 1'b1;
      wait_cyc(8);
    end
  endtask

  // monitor: keeps the last low-phase sdo value, takes it at each rise
  initial begin : mon
    logic       prev_v, cand;
    logic [7:0] sh;
    int         nb;
    prev_v = 1'b1; cand = 1'b1; sh = '0; nb = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!(ext_mode ? sclk_in : sclk_out)) cand = sdo;
        else if (!prev_v) begin
          sh = {cand, sh[7:1]};
          nb++;
          if (nb == 8) begin
            nb = 0;
            if (exp_q.size() > 0) begin
              logic [7:0] e;
              e = exp_q.pop_front();
              check(sh == e, "R2 sdo byte", sh, e);
            end
          end
        end
        prev_v = ext_mode ? sclk_in : sclk_out;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    sclk_in = 1'b1; sdi_drv = 1'b1; loop_en = 1'b1; ext_mode = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    bus_read(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
    expect_stat(8'h06, "R1 status");
    check(sclk_out && sdo, "R1 idle lines", {6'd0, sclk_out, sdo}, 8'h03);
    check(!srdy_oe && !sclk_oe, "R1 enables", {6'd0, srdy_oe, sclk_oe}, 8'h00);

    // R12 internal clock drives the pin
    bus_write(2'd0, 8'h07);
    check(sclk_oe == 1'b1, "R12 sclk_oe internal", {7'd0, sclk_oe}, 8'h01);

    // R2 R3 R4 loopback byte
    send_byte(8'hA5);
    wait_cyc(FRAME_WAIT);
    expect_stat(8'h07, "R4 rx_full set");
    bus_read(2'd2, v); check(v == 8'hA5, "R3 rx byte", v, 8'hA5);
    expect_stat(8'h06, "R4 rx_full cleared by read");

    // R11 ready output gating and R5 delayed tx_done
    bus_write(2'd0, 8'h0B);
    check(srdy_oe == 1'b0, "R11 no rx_en", {7'd0, srdy_oe}, 8'h00);
    bus_write(2'd0, 8'h0F);
    check(srdy_oe == 1'b1 && srdy == 1'b0, "R11 enabled idle",
          {6'd0, srdy_oe, srdy}, 8'h02);
    send_byte(8'h5A);
    check(srdy == 1'b1, "R11 srdy byte waiting", {7'd0, srdy}, 8'h01);
    expect_stat(8'h04, "R5 tx_done still 1 after write");
    wait_cyc(12);
    expect_stat(8'h02, "R5 tx_done low after first falling edge");
    wait_cyc(FRAME_WAIT);
    expect_stat(8'h07, "R5 tx_done back at end");
    bus_read(2'd2, v); check(v == 8'h5A, "R3 rx byte 2", v, 8'h5A);
    bus_write(2'd0, 8'h07);

    // R6 overrun
    send_byte(8'h3C); wait_cyc(FRAME_WAIT);
    send_byte(8'hC3); wait_cyc(FRAME_WAIT);
    expect_stat(8'h1F, "R6 overrun and err_sum");
    // R8 port enable clear
    bus_write(2'd0, 8'h06);
    expect_stat(8'h17, "R8 only overrun cleared");
    bus_write(2'd0, 8'h07);
    // R9 status write
    send_byte(8'h11); wait_cyc(FRAME_WAIT);
    expect_stat(8'h1F, "R9 overrun again");
    bus_write(2'd1, 8'h5C);
    expect_stat(8'h07, "R9 status write clears both");
    // R10 receive enable clear
    send_byte(8'h22); wait_cyc(FRAME_WAIT);
    expect_stat(8'h1F, "R10 overrun again");
    bus_write(2'd0, 8'h03);
    expect_stat(8'h07, "R10 rx_en clear clears both");
    bus_write(2'd0, 8'h07);
    // R7 first byte survived all overruns
    bus_read(2'd2, v); check(v == 8'h3C, "R7 buffer kept", v, 8'h3C);
    expect_stat(8'h06, "R4 cleared after overrun read");

    // R12 R13 external clock
    loop_en = 1'b0;
    bus_write(2'd0, 8'h17);
    ext_mode = 1'b1;
    check(sclk_oe == 1'b0, "R12 sclk_oe external", {7'd0, sclk_oe}, 8'h00);
    send_byte(8'h5E);
    wait_cyc(40);
    expect_stat(8'h04, "R13 no shifting without clock");
    check(sdo == 1'b1, "R13 sdo idle", {7'd0, sdo}, 8'h01);
    ext_frame(8'h93);
    wait_cyc(10);
    expect_stat(8'h07, "R12 external frame done");
    bus_read(2'd2, v); check(v == 8'h93, "R12 external rx byte", v, 8'h93);

    wait_cyc(5);
    check(exp_q.size() == 0, "R2 all frames seen", 8'(exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule